// File: doc/BRIEF.md
# Snooping Line Coherence Controller

This block keeps the four-state coherence tag of every cache line in a small group of snooping caches. Each core has a line controller holding a two-bit state per line. A core asks for a read or a write to one line index and holds the request until it is acknowledged. Requests that the local state can satisfy finish at once and use no bus. All others go to one shared bus. The bus serves one transaction at a time, and the other caches snoop each transaction.

There are three bus transactions: a plain read, a read-for-ownership, and an upgrade that only invalidates. Each runs through an address/snoop phase, an optional writeback phase and a completion phase. The writeback phase is entered when a snooping cache holds the line modified. It lasts a fixed number of cycles, and the requester is held until it ends. When several cores want the bus in the same cycle, a fixed-priority arbiter grants the lowest core index. Upgrades that lose to an ownership grant on the same line see their copy invalidated, and they retry as a read-for-ownership. The data array, victim choice and multi-line objects belong to the surrounding cache, not to this block. Lines are 64 bytes wide.

Top module: `coh_cluster`

## Requirements
- R1: State encoding is Invalid=2'b00, Shared=2'b01, Exclusive=2'b10, Modified=2'b11. The state of core c, line l appears at state_o[(c*NUM_LINES+l)*2 +: 2]. After reset every line is Invalid.
- R2: A read miss with no valid copy in any other core installs the line as Exclusive. ack_o rises 2 cycles after the request is presented.
- R3: A read miss while another core holds a valid copy installs the line as Shared. Every Exclusive or Modified holder drops to Shared, and Shared holders stay Shared.
- R4: A read of a valid line, or a write to an Exclusive or Modified line, is acknowledged in the same cycle without a bus transaction. A write to an Exclusive line moves it to Modified.
- R5: A write to a Shared line issues an upgrade. Other copies go to Invalid, the requester ends Modified, and ack_o rises 2 cycles after the request.
- R6: A write to an Invalid line issues a read-for-ownership. All other copies go to Invalid, and the requester ends Modified.
- R7: When a snooping core holds the requested line Modified, its wb_o bit is high for exactly WB_CYCLES cycles before completion. The request is acknowledged WB_CYCLES cycles later than without the writeback. The holder then drops to Shared on a read and to Invalid on an ownership request.
- R8: Simultaneous bus requests are granted to the lowest core index first. When two Shared holders write the same line in the same cycle, the lower index ends its upgrade Modified and the other is Invalid in the cycle after. The loser then completes as a read-for-ownership that takes the line away through a writeback.
- R9: For any line, at most one core holds it Exclusive or Modified, and while one does, no other core holds a valid copy.
- R10: During the snoop cycle of a bus transaction, shared_o is high exactly when a core other than the requester holds a valid copy of the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | NUM_CORES | Per-core request, held until acknowledged |
| req_write_i | input | NUM_CORES | Per-core request is a write |
| req_idx_i | input | NUM_CORES*IDX_W | Per-core line index, core c at [c*IDX_W +: IDX_W] |
| ack_o | output | NUM_CORES | Request commits at the next clock edge |
| state_o | output | NUM_CORES*NUM_LINES*2 | All line states |
| wb_o | output | NUM_CORES | Core is writing back a modified line |
| shared_o | output | 1 | Snoop response: another valid copy exists |

## Verification
The hardest case to reach is two Shared holders racing to upgrade the same line in one cycle. The race must lead to an invalidation, a retry as read-for-ownership, and a writeback from the winner. A directed sequence first builds the two Shared copies with reads on an index that random traffic never touches. It then drives both writes in the same cycle and observes the intermediate states between the two completions. Random single-core traffic confined to four indices keeps sharing and dirty snoops frequent. Every latency and writeback window is checked against a bench model.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {ST_I = 2'b00, ST_S = 2'b01, ST_E = 2'b10, ST_M = 2'b11} mesi_e;
  typedef enum logic [1:0] {BC_NONE = 2'b00, BC_RD = 2'b01, BC_RDX = 2'b10, BC_UPG = 2'b11} bus_cmd_e;
  typedef enum logic [1:0] {BP_IDLE = 2'b00, BP_SNOOP = 2'b01, BP_WB = 2'b10, BP_DONE = 2'b11} bus_phase_e;
endpackage

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic                   req_write_i,
  input  logic [IDX_W-1:0]       req_idx_i,
  output logic                   ack_o,
  output logic                   bus_req_o,
  output bus_cmd_e               bus_cmd_o,
  input  bus_phase_e             bus_phase_i,
  input  bus_cmd_e               bus_cmd_i,
  input  logic [IDX_W-1:0]       bus_idx_i,
  input  logic                   bus_mine_i,
  input  logic                   bus_shared_i,
  output logic                   snoop_hit_o,
  output logic                   snoop_dirty_o,
  output logic [NUM_LINES*2-1:0] state_o
);
  mesi_e st_q [NUM_LINES];
  mesi_e cur_st, snp_st;
  logic  hit, idx_busy, local_ack, bus_done;

  assign cur_st   = st_q[req_idx_i];
  assign snp_st   = st_q[bus_idx_i];
  assign hit      = req_write_i ? (cur_st == ST_E || cur_st == ST_M) : (cur_st != ST_I);
  assign idx_busy = (bus_phase_i != BP_IDLE) && (bus_idx_i == req_idx_i);
  assign local_ack = req_valid_i && hit && !idx_busy;
  assign bus_done  = (bus_phase_i == BP_DONE);

  assign bus_req_o = req_valid_i && !hit;
  always_comb begin
    if (!req_write_i)        bus_cmd_o = BC_RD;
    else if (cur_st == ST_S) bus_cmd_o = BC_UPG;
    else                     bus_cmd_o = BC_RDX;
  end

  assign ack_o         = local_ack || (bus_done && bus_mine_i);
  assign snoop_hit_o   = !bus_mine_i && (snp_st != ST_I);
  assign snoop_dirty_o = !bus_mine_i && (snp_st == ST_M);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < NUM_LINES; l++) st_q[l] <= ST_I;
    end else begin
      for (int l = 0; l < NUM_LINES; l++) begin
        if (bus_done && bus_idx_i == IDX_W'(l)) begin
          if (bus_mine_i)
            st_q[l] <= (bus_cmd_i == BC_RD) ? (bus_shared_i ? ST_S : ST_E) : ST_M;
          else if (st_q[l] != ST_I)
            st_q[l] <= (bus_cmd_i == BC_RD) ? ST_S : ST_I;
        end else if (local_ack && req_write_i && req_idx_i == IDX_W'(l)) begin
          st_q[l] <= ST_M;  // silent E->M or M hit
        end
      end
    end
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_out
    assign state_o[l*2 +: 2] = st_q[l];
  end

  // R4: acknowledge only an outstanding request
  a_r4_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> req_valid_i);
  // R7: a dirty snoop must stall the bus in writeback
  a_r7_dirty_stalls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_phase_i == BP_SNOOP && snoop_dirty_o) |=> (bus_phase_i == BP_WB));
  // R7: a modified copy is never dropped without a writeback window
  a_r7_m_kept_in_snoop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_phase_i == BP_SNOOP && snoop_dirty_o) |=> (snp_st == ST_M));
endmodule

// File: rtl/coh_bus_arb.sv
module coh_bus_arb
  import coh_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int IDX_W     = 3,
  parameter int WB_CYCLES = 3,
  localparam int CNT_W    = $clog2(WB_CYCLES + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic     [NUM_CORES-1:0]          bus_req_i,
  input  bus_cmd_e [NUM_CORES-1:0]          cmd_i,
  input  logic     [NUM_CORES-1:0][IDX_W-1:0] idx_i,
  input  logic     [NUM_CORES-1:0]          snoop_hit_i,
  input  logic     [NUM_CORES-1:0]          snoop_dirty_i,
  output bus_phase_e                        phase_o,
  output bus_cmd_e                          cmd_o,
  output logic     [IDX_W-1:0]              idx_o,
  output logic     [NUM_CORES-1:0]          owner_oh_o,
  output logic                              shared_o,
  output logic                              shared_q_o,
  output logic     [NUM_CORES-1:0]          wb_o
);
  bus_phase_e             phase_q;
  bus_cmd_e               cmd_q;
  logic [IDX_W-1:0]       idx_q;
  logic [NUM_CORES-1:0]   owner_q, pick_oh, dirty_q;
  logic                   shared_q;
  logic [CNT_W-1:0]       cnt_q;
  bus_cmd_e               pick_cmd;
  logic [IDX_W-1:0]       pick_idx;

  // fixed priority: lowest core index wins
  always_comb begin
    pick_oh  = '0;
    pick_cmd = BC_NONE;
    pick_idx = '0;
    for (int c = NUM_CORES - 1; c >= 0; c--) begin
      if (bus_req_i[c]) begin
        pick_oh  = '0;
        pick_oh[c] = 1'b1;
        pick_cmd = cmd_i[c];
        pick_idx = idx_i[c];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= BP_IDLE;
      cmd_q    <= BC_NONE;
      idx_q    <= '0;
      owner_q  <= '0;
      dirty_q  <= '0;
      shared_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      unique case (phase_q)
        BP_IDLE: if (|bus_req_i) begin
          owner_q <= pick_oh;
          cmd_q   <= pick_cmd;
          idx_q   <= pick_idx;
          phase_q <= BP_SNOOP;
        end
        BP_SNOOP: begin
          shared_q <= |snoop_hit_i;
          dirty_q  <= snoop_dirty_i;
          if (|snoop_dirty_i) begin
            cnt_q   <= CNT_W'(WB_CYCLES - 1);
            phase_q <= BP_WB;
          end else begin
            phase_q <= BP_DONE;
          end
        end
        BP_WB: begin
          if (cnt_q == '0) phase_q <= BP_DONE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: begin
          phase_q <= BP_IDLE;
          owner_q <= '0;
          dirty_q <= '0;
        end
      endcase
    end
  end

  assign phase_o    = phase_q;
  assign cmd_o      = cmd_q;
  assign idx_o      = idx_q;
  assign owner_oh_o = owner_q;
  assign shared_o   = (phase_q == BP_SNOOP) && (|snoop_hit_i);
  assign shared_q_o = shared_q;
  assign wb_o       = (phase_q == BP_WB) ? dirty_q : '0;

  // checker: length of each writeback window
  logic [CNT_W-1:0] wb_len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              wb_len_q <= '0;
    else if (phase_q == BP_WB) wb_len_q <= wb_len_q + 1'b1;
    else if (phase_q == BP_IDLE) wb_len_q <= '0;
  end

  // R8: grant goes to the lowest requesting index
  a_r8_lowest_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == BP_IDLE && |bus_req_i) |=> (owner_oh_o == $past(bus_req_i & (~bus_req_i + NUM_CORES'(1)))));
  // R8: at most one owner at a time
  a_r8_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(owner_oh_o));
  // R7: writeback lasts exactly WB_CYCLES
  a_r7_wb_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == BP_DONE && $past(phase_q) == BP_WB) |-> (wb_len_q == CNT_W'(WB_CYCLES)));
endmodule

// File: rtl/coh_cluster.sv
module coh_cluster
  import coh_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8,
  parameter int WB_CYCLES = 3,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_CORES-1:0]             req_valid_i,
  input  logic [NUM_CORES-1:0]             req_write_i,
  input  logic [NUM_CORES*IDX_W-1:0]       req_idx_i,
  output logic [NUM_CORES-1:0]             ack_o,
  output logic [NUM_CORES*NUM_LINES*2-1:0] state_o,
  output logic [NUM_CORES-1:0]             wb_o,
  output logic                             shared_o
);
  logic     [NUM_CORES-1:0]            bus_req, snoop_hit, snoop_dirty, owner_oh;
  bus_cmd_e [NUM_CORES-1:0]            req_cmd;
  logic     [NUM_CORES-1:0][IDX_W-1:0] req_idx;
  bus_phase_e                          bus_phase;
  bus_cmd_e                            bus_cmd;
  logic     [IDX_W-1:0]                bus_idx;
  logic                                bus_shared;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign req_idx[c] = req_idx_i[c*IDX_W +: IDX_W];
    coh_line_ctrl #(.NUM_LINES(NUM_LINES)) u_line (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_valid_i  (req_valid_i[c]),
      .req_write_i  (req_write_i[c]),
      .req_idx_i    (req_idx[c]),
      .ack_o        (ack_o[c]),
      .bus_req_o    (bus_req[c]),
      .bus_cmd_o    (req_cmd[c]),
      .bus_phase_i  (bus_phase),
      .bus_cmd_i    (bus_cmd),
      .bus_idx_i    (bus_idx),
      .bus_mine_i   (owner_oh[c]),
      .bus_shared_i (bus_shared),
      .snoop_hit_o  (snoop_hit[c]),
      .snoop_dirty_o(snoop_dirty[c]),
      .state_o      (state_o[c*NUM_LINES*2 +: NUM_LINES*2])
    );
  end

  coh_bus_arb #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .WB_CYCLES(WB_CYCLES)) u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_req_i    (bus_req),
    .cmd_i        (req_cmd),
    .idx_i        (req_idx),
    .snoop_hit_i  (snoop_hit),
    .snoop_dirty_i(snoop_dirty),
    .phase_o      (bus_phase),
    .cmd_o        (bus_cmd),
    .idx_o        (bus_idx),
    .owner_oh_o   (owner_oh),
    .shared_o     (shared_o),
    .shared_q_o   (bus_shared),
    .wb_o         (wb_o)
  );

  // R9: single-owner invariant per line
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_inv
    logic [NUM_CORES-1:0] own_v, val_v;
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_bits
      assign own_v[c] = state_o[(c*NUM_LINES+l)*2+1];
      assign val_v[c] = |state_o[(c*NUM_LINES+l)*2 +: 2];
    end
    a_r9_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(own_v) <= 1);
    a_r9_owner_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|own_v) |-> ($countones(val_v) == 1));
  end
endmodule

// File: tb/coh_cluster_tb.sv
`timescale 1ns/1ps
module coh_cluster_tb_top;
  localparam int NC = 4;
  localparam int NL = 8;
  localparam int W  = 3;
  localparam int IW = $clog2(NL);
  localparam logic [1:0] I_ = 2'b00, S_ = 2'b01, E_ = 2'b10, M_ = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NC-1:0] req_valid = '0, req_write = '0;
  logic [NC*IW-1:0] req_idx = '0;
  logic [NC-1:0] ack, wb;
  logic [NC*NL*2-1:0] state;
  logic shared;

  int n_chk = 0, n_fail = 0;
  logic [1:0] mdl [NC][NL];

  always #2 clk = ~clk;

  coh_cluster #(.NUM_CORES(NC), .NUM_LINES(NL), .WB_CYCLES(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_idx_i(req_idx), .ack_o(ack), .state_o(state), .wb_o(wb), .shared_o(shared));

  function automatic logic [1:0] st(int c, int l);
    return state[(c*NL+l)*2 +: 2];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    for (int c = 0; c < NC; c++)
      for (int l = 0; l < NL; l++)
        check(st(c, l) == mdl[c][l], req, $sformatf("state c%0d l%0d", c, l), st(c, l), mdl[c][l]);
    for (int l = 0; l < NL; l++) begin
      int own = 0, val = 0;
      for (int c = 0; c < NC; c++) begin
        if (st(c, l)[1]) own++;
        if (st(c, l) != I_) val++;
      end
      check(own <= 1 && (own == 0 || val == 1), "R9", $sformatf("owner invariant l%0d", l), own, 1);
    end
  endtask

  task automatic do_op(int c, int l, bit w);
    logic [1:0] s = mdl[c][l];
    bit hit = w ? (s == E_ || s == M_) : (s != I_);
    bit oth = 0;
    int d = -1, exp_lat, lat = 0, wbn = 0;
    string tag;
    for (int k = 0; k < NC; k++)
      if (k != c && mdl[k][l] != I_) begin
        oth = 1;
        if (mdl[k][l] == M_) d = k;
      end
    if (hit) begin
      exp_lat = 0; tag = "R4";
      if (w) mdl[c][l] = M_;
    end else begin
      exp_lat = 2 + ((d >= 0) ? W : 0);
      if (!w) begin
        tag = oth ? "R3" : "R2";
        for (int k = 0; k < NC; k++) if (k != c && mdl[k][l] != I_) mdl[k][l] = S_;
        mdl[c][l] = oth ? S_ : E_;
      end else begin
        tag = (s == S_) ? "R5" : "R6";
        for (int k = 0; k < NC; k++) if (k != c) mdl[k][l] = I_;
        mdl[c][l] = M_;
      end
      if (d >= 0) tag = "R7";
    end
    req_valid[c] = 1'b1; req_write[c] = w; req_idx[c*IW +: IW] = IW'(l);
    forever begin
      #1;
      if (!hit && lat == 1) check(shared == oth, "R10", "shared_o in snoop", shared, oth);
      if (wb != '0) begin
        wbn++;
        check(d >= 0 && wb == NC'(1 << d), "R7", "wb_o owner", wb, (d >= 0) ? (1 << d) : 0);
      end
      if (ack[c] || lat > 40) break;
      @(negedge clk); lat++;
    end
    check(lat == exp_lat, tag, "ack latency", lat, exp_lat);
    check(wbn == ((d >= 0 && !hit) ? W : 0), "R7", "writeback cycles", wbn, (d >= 0 && !hit) ? W : 0);
    @(posedge clk); #1 req_valid[c] = 1'b0;
    @(negedge clk);
    compare_all(tag);
  endtask

  // R8: two Shared holders write the same line in one cycle
  task automatic race(int a, int b, int l);
    int lat = 0, la = -1, lb = -1;
    req_valid[a] = 1; req_write[a] = 1; req_idx[a*IW +: IW] = IW'(l);
    req_valid[b] = 1; req_write[b] = 1; req_idx[b*IW +: IW] = IW'(l);
    forever begin
      #1;
      if (lat == 3) begin
        check(st(a, l) == M_, "R8", "winner after upgrade", st(a, l), M_);
        check(st(b, l) == I_, "R8", "loser invalidated", st(b, l), I_);
      end
      if (ack[a] && la < 0) la = lat;
      if (ack[b] && lb < 0) lb = lat;
      @(posedge clk); #1;
      if (la >= 0) req_valid[a] = 0;
      if (lb >= 0) req_valid[b] = 0;
      if ((la >= 0 && lb >= 0) || lat > 60) break;
      @(negedge clk); lat++;
    end
    @(negedge clk);
    check(la == 2, "R8", "winner ack latency", la, 2);
    check(lb == 5 + W, "R8", "loser ack latency", lb, 5 + W);
    for (int k = 0; k < NC; k++) mdl[k][l] = I_;
    mdl[b][l] = M_;
    compare_all("R8");
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int c = 0; c < NC; c++) for (int l = 0; l < NL; l++) mdl[c][l] = I_;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1");
    // directed
    do_op(0, 4, 0);  // R2 exclusive
    do_op(1, 4, 0);  // R3 shared
    do_op(1, 4, 1);  // R5 upgrade
    do_op(2, 4, 0);  // R7 dirty read
    do_op(3, 4, 1);  // R6 write miss
    do_op(0, 4, 1);  // R7 dirty ownership
    do_op(2, 5, 0);  // R2
    do_op(2, 5, 1);  // R4 silent E->M
    do_op(2, 5, 0);  // R4 read hit
    do_op(1, 7, 0);
    do_op(3, 7, 0);
    race(1, 3, 7);   // R8
    // random on a small index set
    for (int i = 0; i < 400; i++)
      do_op($urandom_range(0, NC-1), $urandom_range(0, 3), 1'($urandom_range(0, 1)));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule